// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block brings an EDO DRAM out of power-up and then keeps its contents alive. After reset it holds every strobe inactive for a programmable pause, then runs a fixed number of CAS-before-RAS warm-up cycles on its own. Only after that does it raise `init_done_o` and let the access controller use the memory.

In normal operation a free-running interval timer counts out one refresh slot per period. Each slot adds one to a small backlog counter. While the backlog is non-empty the block raises a request. When the access controller grants it, the block drives RAS and CAS through one CAS-before-RAS cycle, with WE held high. The DRAM supplies the row from its internal counter, so no address is produced. If the controller keeps refusing, the backlog fills. At the limit the block flags urgency and withholds host acknowledges, so the controller must grant. Slots that arrive while the backlog is full are lost.

All timing is counted in clock cycles. The defaults assume a 125 MHz clock: 200 µs pause, one refresh about every 15.6 µs, 104 ns CBR cycle.

Top module: `rfsh_seq`

## Requirements
- R1: For the first PAUSE_CYC cycles after reset release, `ras_no` and `cas_no` stay high, `init_done_o` is low and `bus_own_o` is high.
- R2: After the pause, exactly WARMUP CBR cycles run without any grant, each taking T_CSR+T_RAS+T_RP busy cycles plus one idle cycle. `init_done_o` first reads high after PAUSE_CYC + WARMUP*(T_CSR+T_RAS+T_RP+1) clock edges and stays high.
- R3: In every refresh cycle, `cas_no` is low for exactly T_CSR cycles before `ras_no` falls.
- R4: After `ras_no` falls, `cas_no` stays low for exactly T_CHR cycles, then returns high while `ras_no` is still low.
- R5: `ras_no` stays low for exactly T_RAS cycles. Between two refresh cycles it stays high for at least T_RP+T_CSR cycles.
- R6: `we_no` is high whenever a strobe is low.
- R7: `cas_no` has been high for at least T_CPN cycles before each falling edge.
- R8: After init, each INTERVAL cycles adds one pending refresh. The first slot lands INTERVAL edges after `init_done_o` rises. A refresh starts, with `cas_no` falling one edge later, only in a cycle where `ref_req_o` and `ref_gnt_i` are both high.
- R9: Pending refreshes accumulate up to MAX_PEND, and further slots are dropped. Under continuous grant the backlog drains back to back.
- R10: `ref_urgent_o` is high exactly while MAX_PEND refreshes are pending. It implies `ref_req_o` or `bus_own_o`.
- R11: `host_ack_o` is high only when all of these hold: `host_req_i` is high, init is done, the engine is idle, the block is not urgent, and no refresh starts this cycle.
- R12: `bus_own_o` is high whenever `ras_no` or `cas_no` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_gnt_i | input | 1 | Controller grants the memory bus for one refresh |
| host_req_i | input | 1 | Controller asks whether a normal access may start |
| ref_req_o | output | 1 | Refresh pending and engine idle |
| ref_urgent_o | output | 1 | Backlog full; grant required |
| host_ack_o | output | 1 | Normal access allowed this cycle |
| bus_own_o | output | 1 | Sequencer drives the strobes |
| init_done_o | output | 1 | Pause and warm-up complete |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| we_no | output | 1 | Write enable, active low (held high) |

## Verification
A stuck or mis-stepped engine state shows on the next strobe edge. The run lengths of `cas_no` and `ras_no` around each fall of RAS change, so the error is visible within one refresh cycle. A wrong pause or warm-up count moves the `init_done_o` edge by a computable number of cycles. A backlog counter that miscounts or fails to saturate shows only when the backlog drains: the number of RAS falls in a burst released after a known number of interval slots differs from the expected count. That can be as late as MAX_PEND intervals after the error.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_SETUP,
    ENG_ACT,
    ENG_PRE
  } eng_state_e;
endpackage

// File: rtl/rfsh_cbr_engine.sv
module rfsh_cbr_engine
  import rfsh_pkg::*;
#(
  parameter int T_CSR = 2,
  parameter int T_RAS = 8,
  parameter int T_CHR = 2,
  parameter int T_RP  = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o,
  output logic ras_no,
  output logic cas_no,
  output logic we_no
);
  localparam int CW = $clog2(T_CSR + T_RAS + T_RP + 1);
  localparam logic [CW-1:0] LAST_CSR = CW'(T_CSR - 1);
  localparam logic [CW-1:0] LAST_RAS = CW'(T_RAS - 1);
  localparam logic [CW-1:0] LAST_RP  = CW'(T_RP - 1);
  localparam logic [CW-1:0] CHR_LIM  = CW'(T_CHR);

  eng_state_e     state_q;
  logic [CW-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ENG_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ENG_IDLE: if (start_i) begin
          state_q <= ENG_SETUP;
          cnt_q   <= '0;
        end
        ENG_SETUP: if (cnt_q == LAST_CSR) begin
          state_q <= ENG_ACT;
          cnt_q   <= '0;
        end else cnt_q <= cnt_q + 1'b1;
        ENG_ACT: if (cnt_q == LAST_RAS) begin
          state_q <= ENG_PRE;
          cnt_q   <= '0;
        end else cnt_q <= cnt_q + 1'b1;
        ENG_PRE: if (cnt_q == LAST_RP) begin
          state_q <= ENG_IDLE;
          cnt_q   <= '0;
        end else cnt_q <= cnt_q + 1'b1;
        default: state_q <= ENG_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ENG_IDLE);
  assign done_o = (state_q == ENG_PRE) && (cnt_q == LAST_RP);
  assign ras_no = (state_q != ENG_ACT);
  // CAS leads RAS through SETUP, then is held for T_CHR cycles of ACT
  assign cas_no = !((state_q == ENG_SETUP) ||
                    ((state_q == ENG_ACT) && (cnt_q < CHR_LIM)));
  assign we_no  = 1'b1;
endmodule

// File: rtl/rfsh_interval.sv
module rfsh_interval #(
  parameter int INTERVAL = 1950
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int IW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [IW-1:0] LAST = IW'(INTERVAL - 1);

  logic [IW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!en_i)       cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && (cnt_q == LAST);
endmodule

// File: rtl/rfsh_pending.sv
module rfsh_pending #(
  parameter int MAX_PEND = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic dec_i,
  output logic any_o,
  output logic full_o
);
  localparam int PW = $clog2(MAX_PEND + 1);
  localparam logic [PW-1:0] TOP = PW'(MAX_PEND);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (inc_i && !dec_i && !full_o) cnt_q <= cnt_q + 1'b1;
    else if (dec_i && !inc_i && any_o)   cnt_q <= cnt_q - 1'b1;
  end

  assign any_o  = (cnt_q != '0);
  assign full_o = (cnt_q == TOP);
endmodule

// File: rtl/rfsh_seq.sv
module rfsh_seq #(
  parameter int PAUSE_CYC = 25000,
  parameter int WARMUP    = 8,
  parameter int INTERVAL  = 1950,
  parameter int MAX_PEND  = 8,
  parameter int T_CSR     = 2,
  parameter int T_RAS     = 8,
  parameter int T_CHR     = 2,
  parameter int T_RP      = 5,
  parameter int T_CPN     = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_gnt_i,
  input  logic host_req_i,
  output logic ref_req_o,
  output logic ref_urgent_o,
  output logic host_ack_o,
  output logic bus_own_o,
  output logic init_done_o,
  output logic ras_no,
  output logic cas_no,
  output logic we_no
);
  localparam int PCW = $clog2(PAUSE_CYC + 1);
  localparam int WCW = $clog2(WARMUP + 1);
  localparam logic [PCW-1:0] PAUSE_LAST = PCW'(PAUSE_CYC - 1);
  localparam logic [WCW-1:0] WARM_TOP   = WCW'(WARMUP);

  logic [PCW-1:0] pause_cnt_q;
  logic           pause_done_q;
  logic [WCW-1:0] warm_cnt_q;
  logic           busy, done, tick, pend_any, pend_full;
  logic           warm_go, grant_go, eng_start;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pause_cnt_q  <= '0;
      pause_done_q <= 1'b0;
    end else if (!pause_done_q) begin
      if (pause_cnt_q == PAUSE_LAST) pause_done_q <= 1'b1;
      else                           pause_cnt_q  <= pause_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    warm_cnt_q <= '0;
    else if (done && !init_done_o)  warm_cnt_q <= warm_cnt_q + 1'b1;
  end

  assign init_done_o = (warm_cnt_q == WARM_TOP);
  assign warm_go     = pause_done_q && !init_done_o && !busy;
  assign ref_req_o   = init_done_o && pend_any && !busy;
  assign grant_go    = ref_req_o && ref_gnt_i;
  assign eng_start   = warm_go || grant_go;

  assign ref_urgent_o = pend_full;
  assign bus_own_o    = !init_done_o || busy;
  assign host_ack_o   = host_req_i && init_done_o && !busy && !pend_full && !grant_go;

  rfsh_interval #(.INTERVAL(INTERVAL)) u_interval (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (init_done_o),
    .tick_o(tick)
  );

  rfsh_pending #(.MAX_PEND(MAX_PEND)) u_pending (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (tick),
    .dec_i (grant_go),
    .any_o (pend_any),
    .full_o(pend_full)
  );

  rfsh_cbr_engine #(
    .T_CSR(T_CSR), .T_RAS(T_RAS), .T_CHR(T_CHR), .T_RP(T_RP)
  ) u_engine (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(eng_start),
    .busy_o (busy),
    .done_o (done),
    .ras_no (ras_no),
    .cas_no (cas_no),
    .we_no  (we_no)
  );
endmodule

// File: rtl/rfsh_seq_chk.sv
module rfsh_seq_chk #(
  parameter int T_CSR = 2,
  parameter int T_RAS = 8,
  parameter int T_CHR = 2,
  parameter int T_CPN = 2
) (
  input logic clk_i,
  input logic rst_ni,
  input logic ref_gnt_i,
  input logic host_req_i,
  input logic ref_req_o,
  input logic ref_urgent_o,
  input logic host_ack_o,
  input logic bus_own_o,
  input logic init_done_o,
  input logic ras_no,
  input logic cas_no,
  input logic we_no
);
  logic [15:0] cas_lo_run, cas_hi_run, ras_lo_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cas_lo_run <= '0;
      cas_hi_run <= '0;
      ras_lo_run <= '0;
    end else begin
      cas_lo_run <= cas_no ? '0 : ((cas_lo_run == 16'hffff) ? cas_lo_run : cas_lo_run + 1'b1);
      cas_hi_run <= !cas_no ? '0 : ((cas_hi_run == 16'hffff) ? cas_hi_run : cas_hi_run + 1'b1);
      ras_lo_run <= ras_no ? '0 : ((ras_lo_run == 16'hffff) ? ras_lo_run : ras_lo_run + 1'b1);
    end
  end

  assert_cas_lead_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_no) |-> (cas_lo_run == 16'(T_CSR)));

  assert_cas_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cas_no) && !ras_no) |-> (ras_lo_run == 16'(T_CHR)));

  assert_ras_width_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_no) |-> (ras_lo_run == 16'(T_RAS)));

  assert_we_high_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_no || !cas_no) |-> we_no);

  assert_cas_precharge_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cas_no) |-> (cas_hi_run >= 16'(T_CPN)));

  assert_start_on_grant_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_done_o && $fell(cas_no)) |-> $past(ref_req_o && ref_gnt_i));

  assert_urgent_pending_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_urgent_o |-> (ref_req_o || bus_own_o));

  assert_host_ack_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_ack_o |-> (host_req_i && init_done_o && !bus_own_o && !ref_urgent_o));

  assert_init_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o);

  assert_bus_own_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_no || !cas_no) |-> bus_own_o);
endmodule

bind rfsh_seq rfsh_seq_chk #(
  .T_CSR(T_CSR), .T_RAS(T_RAS), .T_CHR(T_CHR), .T_CPN(T_CPN)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ref_gnt_i   (ref_gnt_i),
  .host_req_i  (host_req_i),
  .ref_req_o   (ref_req_o),
  .ref_urgent_o(ref_urgent_o),
  .host_ack_o  (host_ack_o),
  .bus_own_o   (bus_own_o),
  .init_done_o (init_done_o),
  .ras_no      (ras_no),
  .cas_no      (cas_no),
  .we_no       (we_no)
);

// File: tb/tb_rfsh_seq.sv
module tb_rfsh_seq;
  localparam int PAUSE = 200;
  localparam int WARM  = 8;
  localparam int IVL   = 300;
  localparam int MAXP  = 8;
  localparam int CSR   = 2;
  localparam int RAS   = 8;
  localparam int CHR   = 2;
  localparam int RP    = 5;
  localparam int CPN   = 2;
  localparam int HALF  = IVL / 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ref_gnt_i = 1'b0;
  logic host_req_i = 1'b1;
  logic ref_req_o, ref_urgent_o, host_ack_o, bus_own_o, init_done_o;
  logic ras_no, cas_no, we_no;

  int tests = 0;
  int fails = 0;
  int edge_cnt = 0;
  int post_falls = 0;
  int init_falls = 0;
  int e_init = 0;
  bit done_flag = 1'b0;

  always #4 clk = ~clk;

  rfsh_seq #(
    .PAUSE_CYC(PAUSE), .WARMUP(WARM), .INTERVAL(IVL), .MAX_PEND(MAXP),
    .T_CSR(CSR), .T_RAS(RAS), .T_CHR(CHR), .T_RP(RP), .T_CPN(CPN)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni), .ref_gnt_i(ref_gnt_i), .host_req_i(host_req_i),
    .ref_req_o(ref_req_o), .ref_urgent_o(ref_urgent_o), .host_ack_o(host_ack_o),
    .bus_own_o(bus_own_o), .init_done_o(init_done_o),
    .ras_no(ras_no), .cas_no(cas_no), .we_no(we_no)
  );

  function automatic int exp_init_edge();
    return PAUSE + WARM * (CSR + RAS + RP + 1);
  endfunction

  function automatic int exp_burst(int slots);
    return (slots > MAXP) ? MAXP : slots;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (edge %0d)", req, act, exp, edge_cnt);
    end
  endtask

  task automatic finish_tb();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  task automatic wait_edge(int n);
    forever begin
      @(posedge clk);
      #1;
      if (edge_cnt >= n) break;
    end
  endtask

  always @(posedge clk) if (rst_ni) edge_cnt <= edge_cnt + 1;

  // strobe monitor, sampled away from the active edge
  logic prev_ras = 1'b1, prev_cas = 1'b1, prev_start = 1'b0;
  int ras_lo = 0, ras_hi = 0, cas_lo = 0, cas_hi = 0;
  always @(negedge clk) begin
    if (rst_ni) begin
      if (prev_ras && !ras_no) begin
        chk(cas_lo == CSR, "R3", cas_lo, CSR);
        chk(ras_hi >= RP + CSR, "R5", ras_hi, RP + CSR);
        if (init_done_o) post_falls++; else init_falls++;
      end
      if (!prev_ras && ras_no) chk(ras_lo == RAS, "R5", ras_lo, RAS);
      if (!prev_cas && cas_no) chk(!ras_no && ras_lo == CHR, "R4", ras_lo, CHR);
      if (prev_cas && !cas_no) begin
        chk(cas_hi >= CPN, "R7", cas_hi, CPN);
        if (init_done_o) chk(prev_start, "R8", prev_start, 1);
      end
      if (!ras_no || !cas_no) begin
        chk(we_no, "R6", we_no, 1);
        chk(bus_own_o, "R12", bus_own_o, 1);
      end
      if (edge_cnt <= PAUSE)
        chk(ras_no && cas_no && !init_done_o && bus_own_o, "R1",
            {ras_no, cas_no, init_done_o, bus_own_o}, 4'b1101);
      chk(host_ack_o == (host_req_i && init_done_o && !bus_own_o && !ref_urgent_o &&
                         !(ref_req_o && ref_gnt_i)), "R11", host_ack_o, !host_ack_o);
      chk(!ref_urgent_o || ref_req_o || bus_own_o, "R10", ref_urgent_o, 0);
      ras_lo = ras_no ? 0 : ras_lo + 1;
      ras_hi = ras_no ? ras_hi + 1 : 0;
      cas_lo = cas_no ? 0 : cas_lo + 1;
      cas_hi = cas_no ? cas_hi + 1 : 0;
      prev_ras = ras_no;
      prev_cas = cas_no;
      prev_start = ref_req_o && ref_gnt_i;
    end
  end

  initial begin
    #(8 * 200000);
    chk(1'b0, "watchdog", edge_cnt, 0);
    finish_tb();
  end

  initial begin
    int base;
    void'($urandom(32'h5eed_1234));
    // reset state
    #3;
    chk(ras_no && cas_no && !init_done_o && !ref_req_o && !host_ack_o, "R1",
        {ras_no, cas_no}, 2'b11);
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;

    wait_edge(PAUSE / 2);
    chk(ras_no && cas_no && !init_done_o && bus_own_o, "R1", ras_no, 1);
    chk(!host_ack_o, "R11", host_ack_o, 0);

    forever begin
      @(posedge clk);
      #1;
      if (init_done_o || edge_cnt > 5 * PAUSE) break;
    end
    e_init = edge_cnt;
    chk(e_init == exp_init_edge(), "R2", e_init, exp_init_edge());
    chk(init_falls == WARM, "R2", init_falls, WARM);

    // continuous grant: one refresh per interval
    ref_gnt_i = 1'b1;
    wait_edge(e_init + 5 * IVL + HALF);
    chk(post_falls == 5, "R8", post_falls, 5);
    chk(host_ack_o && !ref_urgent_o, "R11", host_ack_o, 1);

    // withheld grant, three slots queued
    ref_gnt_i = 1'b0;
    base = post_falls;
    wait_edge(e_init + 8 * IVL + HALF);
    chk(post_falls == base, "R8", post_falls - base, 0);
    chk(ref_req_o && !ref_urgent_o, "R10", ref_urgent_o, 0);
    ref_gnt_i = 1'b1;
    wait_edge(e_init + 8 * IVL + HALF + 140);
    chk(post_falls - base == exp_burst(3), "R9", post_falls - base, exp_burst(3));

    // eleven slots withheld: saturate
    wait_edge(e_init + 9 * IVL + HALF);
    ref_gnt_i = 1'b0;
    base = post_falls;
    wait_edge(e_init + 20 * IVL + HALF);
    chk(ref_urgent_o, "R10", ref_urgent_o, 1);
    chk(!host_ack_o, "R11", host_ack_o, 0);
    ref_gnt_i = 1'b1;
    wait_edge(e_init + 20 * IVL + HALF + 140);
    chk(post_falls - base == exp_burst(11), "R9", post_falls - base, exp_burst(11));
    chk(!ref_urgent_o, "R10", ref_urgent_o, 0);

    // random grant and host traffic over twenty slots
    wait_edge(e_init + 21 * IVL + HALF);
    base = post_falls;
    while (edge_cnt < e_init + 41 * IVL + HALF) begin
      ref_gnt_i  = ($urandom % 4) != 0;
      host_req_i = ($urandom % 2) != 0;
      @(posedge clk);
      #1;
    end
    ref_gnt_i = 1'b1;
    host_req_i = 1'b1;
    wait_edge(e_init + 41 * IVL + HALF + 140);
    chk(post_falls - base == 20, "R9", post_falls - base, 20);
    chk(init_done_o, "R2", init_done_o, 1);

    finish_tb();
  end
endmodule